// File: doc/BRIEF.md
# I2C Register-File Slave

This block lets an external I2C master read and write a private bank of byte-wide registers. An oversampling system clock samples SCL and SDA. Each line passes through a two-flop synchroniser and a stability filter, and START, repeated START and STOP are then decoded from the filtered lines. The block answers to a 7-bit device address made of the fixed prefix `110000` and a strap input as the low bit. It holds SDA low only through an open-drain enable. It never stretches the clock, and it does not recognise general call or 10-bit addresses.

A write transaction loads an internal register pointer from the first byte after the address byte. Every further byte is stored at the pointer, and the pointer then advances. To read, the master first sets the pointer with a write transaction. It then sends a read address, either after STOP and START or after a repeated START, and the block returns bytes starting at that pointer. The pointer advances after each byte it loads for sending. If the slave holds SDA low for too long, a watchdog releases the line and returns the slave to idle.

The controller is a single state machine with these states:
- `ST_IDLE` waits for START.
- `ST_ADDR` shifts in the address byte. On the eighth SCL fall it goes to `ST_ADDR_ACK` when the address matches and to `ST_IGNORE` when it does not.
- `ST_ADDR_ACK` drives ACK. On the next fall it goes to `ST_PTR` for a write, or loads the first byte and goes to `ST_RDATA` for a read.
- `ST_PTR` receives the pointer byte and goes to `ST_PTR_ACK`.
- `ST_PTR_ACK` drives ACK and goes to `ST_WDATA`.
- `ST_WDATA` receives a data byte, stores it, and goes to `ST_WDATA_ACK`.
- `ST_WDATA_ACK` drives ACK and returns to `ST_WDATA`.
- `ST_RDATA` shifts out eight bits and goes to `ST_RDATA_ACK`.
- `ST_RDATA_ACK` samples the master's answer. On ACK it reloads and returns to `ST_RDATA`; on NACK it goes to `ST_IGNORE`.
- `ST_IGNORE` waits for the next START or STOP.

In any state, START goes to `ST_ADDR`, STOP goes to `ST_IDLE`, and the timeout goes to `ST_IDLE`.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The slave drives ACK (`sda_oe`=1 through the ninth SCL clock) after an address byte whose upper seven bits equal `110000` followed by `addr_strap`. Bit 0 of that byte is R/W, where 0 means write and 1 means read.
- R2: After an address byte that does not match, the slave never asserts `sda_oe` and writes no register until the next START.
- R3: In a write transaction, the byte after the address byte sets the pointer, and the next data byte is stored at that pointer. Bytes are sent MSB first, and the slave ACKs every one of them.
- R4: Each further data byte in the same write transaction is stored at the previous location plus one.
- R5: A read transaction returns, MSB first, the register addressed by the pointer that an earlier write transaction set. The slave pulls SDA low for 0 bits and releases it for 1 bits.
- R6: While the master ACKs, a read continues with consecutive registers. After a NACK the slave leaves SDA released.
- R7: The pointer wraps from 0xFF to 0x00 on both writes and reads.
- R8: A repeated START after the pointer byte, without a STOP, begins a new transaction that reads from that pointer.
- R9: If `sda_oe` stays asserted for `TMO_CYCLES` consecutive system clocks, it is released after exactly that many cycles. The slave then stays silent until a new START.
- R10: `sda_oe` changes only while SCL is low.
- R11: After reset, `sda_oe` is 0 and every register reads as 0x00.
- R12: A pulse on SCL that lasts fewer than `FILT_CYCLES` system clocks has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least ten times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| addr_strap | input | 1 | Low bit of the device address |
| sda_oe | output | 1 | When 1, the SDA pad pulls the line low |

## Verification
The assertions assume a master that obeys the bus rules. It changes SDA only while SCL is low, except when it forms START or STOP. It never tries to create START or STOP while the slave is holding SDA low. It leaves `addr_strap` unchanged during a transaction. The bench's master keeps SCL high and low for 20 system clocks each. It moves SDA two clocks after each SCL fall, so every edge reaches the filters well apart from the others. The strap changes only between transactions. The two deliberate disturbances are still legal bus behaviour: a two-clock SCL pulse inside a low phase, and an SCL held low during ACK until the timeout fires.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam logic [5:0] DEV_PREFIX = 6'b110000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } slv_state_e;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int STABLE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= 2'b11;
            run_cnt  <= '0;
            line_out <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_in};
            if (sync_q[1] == line_out) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(STABLE_CYCLES - 1)) begin
                line_out <= sync_q[1];
                run_cnt  <= '0;
            end else begin
                run_cnt <= run_cnt + CW'(1);
            end
        end
    end

    // a new output level must have been present on the synchronised line for two cycles before
    AST_FILTER_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_out) |-> ($past(sync_q[1], 1) == line_out && $past(sync_q[1], 2) == line_out)); // R12

endmodule

// File: rtl/i2c_reg_mem.sv
module i2c_reg_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2c_rf_pkg::*;
#(
    parameter int FILT_CYCLES = 3,
    parameter int TMO_CYCLES  = 3125000,
    parameter int REG_AW      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic addr_strap,
    output logic sda_oe
);
    localparam int TMO_W = $clog2(TMO_CYCLES + 1);
    localparam int BYTE_W = 8;

    logic [1:0] raw_lines, flt_lines;
    assign raw_lines = {scl_in, sda_in};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2c_line_filter #(.STABLE_CYCLES(FILT_CYCLES)) u_flt (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (raw_lines[g]),
            .line_out (flt_lines[g])
        );
    end

    logic scl_f, sda_f, scl_d, sda_d;
    logic scl_rise, scl_fall, start_c, stop_c;
    assign scl_f    = flt_lines[1];
    assign sda_f    = flt_lines[0];
    assign scl_rise = scl_f & ~scl_d;
    assign scl_fall = ~scl_f & scl_d;
    assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;

    slv_state_e        state, state_n;
    logic [3:0]        bit_cnt, bit_n;
    logic [BYTE_W-1:0] shreg, sh_n;
    logic [REG_AW-1:0] ptr, ptr_n;
    logic              tx_more, more_n;
    logic              mem_we;
    logic [BYTE_W-1:0] mem_rdata;
    logic [TMO_W-1:0]  tmo_cnt;
    logic              tmo_hit, addr_hit;

    assign addr_hit = (shreg[7:1] == {DEV_PREFIX, addr_strap});
    assign tmo_hit  = sda_oe && (tmo_cnt == TMO_W'(TMO_CYCLES - 1));

    i2c_reg_mem #(.AW(REG_AW), .DW(BYTE_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .wr_addr (ptr),
        .wr_data (shreg),
        .rd_addr (ptr),
        .rd_data (mem_rdata)
    );

    // next-state and datapath decisions
    always_comb begin
        state_n = state;
        bit_n   = bit_cnt;
        sh_n    = shreg;
        ptr_n   = ptr;
        more_n  = tx_more;
        mem_we  = 1'b0;
        if (tmo_hit) begin
            state_n = ST_IDLE;
        end else if (start_c) begin
            state_n = ST_ADDR;
            bit_n   = '0;
        end else if (stop_c) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        sh_n  = {shreg[6:0], sda_f};
                        bit_n = bit_cnt + 4'd1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        bit_n = '0;
                        if (state == ST_ADDR) begin
                            state_n = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                        end else if (state == ST_PTR) begin
                            ptr_n   = shreg[REG_AW-1:0];
                            state_n = ST_PTR_ACK;
                        end else begin
                            mem_we  = 1'b1;
                            ptr_n   = ptr + REG_AW'(1);
                            state_n = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (shreg[0]) begin
                            state_n = ST_RDATA;
                            sh_n    = mem_rdata;
                            ptr_n   = ptr + REG_AW'(1);
                            bit_n   = '0;
                        end else begin
                            state_n = ST_PTR;
                        end
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) state_n = ST_WDATA;
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            state_n = ST_RDATA_ACK;
                            bit_n   = '0;
                        end else begin
                            sh_n  = {shreg[6:0], 1'b0};
                            bit_n = bit_cnt + 4'd1;
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        more_n = ~sda_f;
                    end else if (scl_fall) begin
                        if (tx_more) begin
                            state_n = ST_RDATA;
                            sh_n    = mem_rdata;
                            ptr_n   = ptr + REG_AW'(1);
                        end else begin
                            state_n = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            tx_more <= 1'b0;
            scl_d   <= 1'b1;
            sda_d   <= 1'b1;
            tmo_cnt <= '0;
        end else begin
            state   <= state_n;
            bit_cnt <= bit_n;
            shreg   <= sh_n;
            ptr     <= ptr_n;
            tx_more <= more_n;
            scl_d   <= scl_f;
            sda_d   <= sda_f;
            tmo_cnt <= sda_oe ? tmo_cnt + TMO_W'(1) : '0;
        end
    end

    // open-drain output decode
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~shreg[7];
            default:                               sda_oe = 1'b0;
        endcase
    end

    AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> (shreg[7:1] == {DEV_PREFIX, addr_strap})); // R1

    AST_WRITE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ptr == $past(ptr) + REG_AW'(1))); // R4

    AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && tmo_cnt == TMO_W'(TMO_CYCLES - 1)) |=> (!sda_oe && state == ST_IDLE)); // R9

    AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && scl_d && !tmo_hit) |=> $stable(sda_oe)); // R10

endmodule

// File: tb/i2c_regfile_slave_test.sv
module i2c_regfile_slave_test;
    localparam int H   = 20;
    localparam int TMO = 600;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, scl_drv, m_low, strap, sda_oe, sda_line;
    assign sda_line = !(m_low || sda_oe);

    i2c_regfile_slave #(.FILT_CYCLES(3), .TMO_CYCLES(TMO), .REG_AW(8)) uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line),
        .addr_strap(strap), .sda_oe(sda_oe)
    );

    int n_cmp = 0, n_bad = 0;
    logic [7:0] ref_mem [256];
    logic [7:0] ref_ptr;
    logic [7:0] wbuf [8];
    logic quiet_chk = 1'b0;
    string quiet_req = "R2";

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // per-clock monitor: SDA steady during SCL high, silence when model expects it
    logic prev_scl = 1'b1, prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_drv && prev_scl) check(sda_oe == prev_oe, "R10", sda_oe, prev_oe);
            if (quiet_chk) check(!sda_oe, quiet_req, sda_oe, 0);
        end
        prev_scl = scl_drv;
        prev_oe  = sda_oe;
    end

    function automatic logic [7:0] dev(input bit lsb, input bit rw);
        return {6'b110000, lsb, rw};
    endfunction

    task automatic i2c_start();
        m_low = 1'b0; tick(H);
        scl_drv = 1'b1; tick(H);
        m_low = 1'b1; tick(H);
        scl_drv = 1'b0;
    endtask

    task automatic i2c_stop();
        tick(2);
        m_low = 1'b1; tick(H);
        scl_drv = 1'b1; tick(H);
        m_low = 1'b0; tick(H);
    endtask

    task automatic clk_bit(input bit b, input bit glitch, output bit r);
        tick(2);
        m_low = !b;
        if (glitch) begin
            tick(H/2);
            scl_drv = 1'b1; tick(2);
            scl_drv = 1'b0; tick(H - H/2 - 4);
        end else begin
            tick(H - 2);
        end
        scl_drv = 1'b1; tick(H/2);
        r = sda_line;
        tick(H - H/2);
        scl_drv = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] d, input bit glitch, output bit ack);
        bit r;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], glitch && (i == 4), r);
        clk_bit(1'b1, 1'b0, r);
        ack = !r;
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] d);
        bit r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, 1'b0, r);
            d[i] = r;
        end
        clk_bit(!mack, 1'b0, r);
    endtask

    task automatic write_txn(input logic [7:0] rg, input int n, input bit glitch, input string req);
        bit ack;
        i2c_start();
        write_byte(dev(strap, 1'b0), 1'b0, ack);
        check(ack, "R1", ack, 1);
        write_byte(rg, 1'b0, ack);
        check(ack, "R3", ack, 1);
        ref_ptr = rg;
        for (int k = 0; k < n; k++) begin
            write_byte(wbuf[k], glitch, ack);
            check(ack, req, ack, 1);
            ref_mem[ref_ptr] = wbuf[k];
            ref_ptr = ref_ptr + 8'd1;
        end
        i2c_stop();
    endtask

    task automatic set_ptr(input logic [7:0] rg, input bit with_stop);
        bit ack;
        i2c_start();
        write_byte(dev(strap, 1'b0), 1'b0, ack);
        check(ack, "R1", ack, 1);
        write_byte(rg, 1'b0, ack);
        check(ack, "R5", ack, 1);
        ref_ptr = rg;
        if (with_stop) i2c_stop();
    endtask

    task automatic read_txn(input int n, input string req);
        bit ack;
        logic [7:0] d;
        i2c_start();
        write_byte(dev(strap, 1'b1), 1'b0, ack);
        check(ack, "R1", ack, 1);
        for (int k = 0; k < n; k++) begin
            read_byte(k != n - 1, d);
            check(d == ref_mem[ref_ptr], req, d, ref_mem[ref_ptr]);
            ref_ptr = ref_ptr + 8'd1;
        end
        tick(8);
        check(!sda_oe, "R6", sda_oe, 0);
        i2c_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] d;
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
        ref_ptr = 8'h00;
        rst_n = 1'b0; scl_drv = 1'b1; m_low = 1'b0; strap = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        check(!sda_oe, "R11", sda_oe, 0);
        set_ptr(8'h33, 1'b1);
        read_txn(2, "R11");

        // single write, then read back
        wbuf[0] = 8'hA5;
        write_txn(8'h05, 1, 1'b0, "R3");
        set_ptr(8'h05, 1'b1);
        read_txn(1, "R3");

        // burst write and burst read
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h80;
        write_txn(8'h20, 4, 1'b0, "R4");
        set_ptr(8'h20, 1'b1);
        read_txn(4, "R6");
        set_ptr(8'h22, 1'b1);
        read_txn(1, "R5");

        // repeated START between pointer byte and read
        set_ptr(8'h05, 1'b0);
        read_txn(1, "R8");
        set_ptr(8'h21, 1'b0);
        read_txn(3, "R8");

        // pointer wrap on write and read
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
        write_txn(8'hFE, 3, 1'b0, "R7");
        set_ptr(8'hFF, 1'b1);
        read_txn(2, "R7");

        // address mismatch: write attempt and read attempt
        quiet_req = "R2"; quiet_chk = 1'b1;
        i2c_start();
        write_byte(dev(1'b1, 1'b0), 1'b0, ack);
        check(!ack, "R2", ack, 0);
        write_byte(8'h05, 1'b0, ack);
        write_byte(8'h77, 1'b0, ack);
        check(!ack, "R2", ack, 0);
        i2c_stop();
        i2c_start();
        write_byte(dev(1'b1, 1'b1), 1'b0, ack);
        read_byte(1'b0, d);
        check(d == 8'hFF, "R2", d, 8'hFF);
        i2c_stop();
        quiet_chk = 1'b0;
        set_ptr(8'h05, 1'b1);
        read_txn(1, "R2");

        // strap high moves the device address
        strap = 1'b1;
        wbuf[0] = 8'h5A;
        write_txn(8'h40, 1, 1'b0, "R1");
        set_ptr(8'h40, 1'b1);
        read_txn(1, "R1");
        strap = 1'b0;

        // short SCL pulses inside low phases
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
        write_txn(8'h50, 2, 1'b1, "R12");
        set_ptr(8'h50, 1'b1);
        read_txn(2, "R12");

        // timeout: hold SCL low during the address ACK
        begin
            int hi;
            bit r;
            hi = 0;
            i2c_start();
            for (int i = 7; i >= 0; i--) clk_bit(dev(1'b0, 1'b0) >> i, 1'b0, r);
            tick(2);
            m_low = 1'b0;
            for (int k = 0; k < 2 * TMO; k++) begin
                tick(1);
                if (sda_oe) hi++;
            end
            check(hi == TMO, "R9", hi, TMO);
            check(!sda_oe, "R9", sda_oe, 0);
            quiet_req = "R9"; quiet_chk = 1'b1;
            write_byte(8'h00, 1'b0, ack);
            check(!ack, "R9", ack, 0);
            i2c_stop();
            quiet_chk = 1'b0;
        end
        set_ptr(8'h20, 1'b1);
        read_txn(2, "R9");

        tick(10);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule